// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer with Hardware Averaging

This block paces an analog-to-digital conversion in units of a derived ADC clock and averages several samples in hardware. A clock enable is produced from the bus clock by a divider chosen in the configuration word. Each conversion starts with a fixed startup period of 6 ADC cycles. Then, for every sample, there is a long-sample window followed by a 25-cycle base conversion. At the end of each base conversion the sample code presented by the converter is added to an accumulator. After the last sample, the sum is shifted right by log2 of the sample count and presented with a one-cycle valid pulse.

A conversion is started by a request pulse. Configuration is captured when the conversion begins. In continuous mode a new conversion starts at once after every result, until the mode is cleared. A stop code on the channel input aborts the conversion in progress at the next ADC clock enable, and no result is produced.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset, `busy`, `resultValid` and `sampleTake` are low.
- R2: The ADC clock period D is 1, 2, 4 or 8 bus cycles for `cfgWord[6:5]` = 0, 1, 2, 3. When `cfgWord[1:0]` = 01 and `cfgWord[6:5]` = 3, D is 16. Other values of `cfgWord[1:0]` have no effect on D.
- R3: `resultValid` rises exactly D*(6 + N*(25 + L)) bus cycles after the clock edge that accepts `startReq`.
- R4: The long-sample length L is set by `cfgWord[4]` and `cfgWord[9:8]` = f. With bit 4 clear, L is 3 + 2f (3, 5, 7, 9). With bit 4 set, L is 13 + 4f (13, 17, 21, 25).
- R5: The sample count N is 1 when `avgEnable` is low. When `avgEnable` is high, N is 4, 8, 16 or 32 for `cfgWord[15:14]` = 0, 1, 2, 3. Exactly N samples are taken per conversion.
- R6: `sampleTake` is high for one cycle per sample, and the code on `sampleCode` in that cycle is the one accumulated. `resultData` equals floor(sum of the N taken codes / N).
- R7: `resultValid` is high for exactly one bus cycle per finished conversion.
- R8: With `contMode` high, a new conversion starts right after each result, with the same latency. When `contMode` is cleared during a conversion, that conversion completes and `busy` then drops.
- R9: `chanCode` = 0x1F during a conversion returns the block to idle at the next ADC clock enable, with no `resultValid`. A `startReq` given with `chanCode` = 0x1F is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start a conversion when idle |
| chanCode | input | 5 | Channel code; 0x1F means stop |
| cfgWord | input | 16 | Divider, clock select, sample time and averaging fields |
| avgEnable | input | 1 | Enable multi-sample averaging |
| contMode | input | 1 | Restart automatically after each result |
| sampleCode | input | CODE_W | Code from the converter stand-in |
| sampleTake | output | 1 | The current `sampleCode` is captured at the next edge |
| busy | output | 1 | A conversion is in progress |
| resultValid | output | 1 | One-cycle result strobe |
| resultData | output | CODE_W | Averaged result |

## Verification
A phase or sample counter that is off by one shows up as a `resultValid` that arrives early or late by a multiple of D cycles. It also shows up as a `sampleTake` count that differs from N. Both are visible at the end of the same conversion. A bad shift or a lost accumulation shows as a wrong `resultData` on the first valid pulse. A broken stop path either leaves `busy` high more than D cycles after the stop code, or lets a late `resultValid` through.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int STARTUP_CYC  = 6;
  localparam int BCT_CYC      = 25;
  localparam int PHASE_W      = 5;
  localparam int MAX_AVG_LOG2 = 5;
  localparam logic [4:0] STOP_CODE = 5'h1F;

  typedef enum logic [1:0] {ST_IDLE, ST_STARTUP, ST_LSAMP, ST_CONVERT} seqState_t;

  typedef struct packed {
    logic       clear;
    logic       take;
    logic       finish;
    logic [2:0] shift;
  } dpStrobe_t;

  function automatic logic [2:0] divLog2Of(input logic [15:0] cfg);
    if (cfg[6:5] == 2'b11 && cfg[1:0] == 2'b01) return 3'd4;
    return {1'b0, cfg[6:5]};
  endfunction

  function automatic logic [PHASE_W-1:0] lstOf(input logic [15:0] cfg);
    if (cfg[4]) return PHASE_W'(13) + PHASE_W'({cfg[9:8], 2'b00});
    return PHASE_W'(3) + PHASE_W'({cfg[9:8], 1'b0});
  endfunction

  function automatic logic [2:0] avgLog2Of(input logic en, input logic [15:0] cfg);
    if (en) return 3'd2 + {1'b0, cfg[15:14]};
    return 3'd0;
  endfunction
endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
  parameter int DIV_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       restart,
  input  logic [2:0] divLog2,
  output logic       tick
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLim;

  always_comb begin
    divLim = DIV_W'(((DIV_W+1)'(1) << divLog2) - (DIV_W+1)'(1));
    tick   = run && !restart && (divCnt == divLim);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                divCnt <= '0;
    else if (restart || !run) divCnt <= '0;
    else if (tick)            divCnt <= '0;
    else                      divCnt <= divCnt + 1'b1;
  end

  // R2: for any divisor above one, ADC enables never come back to back
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && divLog2 != 3'd0 && $stable(divLog2)) |=> !tick);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic [4:0]  chanCode,
  input  logic [15:0] cfgWord,
  input  logic        avgEnable,
  input  logic        contMode,
  input  logic        tick,
  output logic        busy,
  output logic        sampleTake,
  output logic        divRestart,
  output logic [2:0]  divLog2,
  output dpStrobe_t   strobe
);
  seqState_t                 state;
  logic [PHASE_W-1:0]        phaseCnt;
  logic [PHASE_W-1:0]        lstCyc;
  logic [MAX_AVG_LOG2:0]     sampleCnt;
  logic [2:0]                avgLog2;
  logic stopReq, startOk, phaseDone, takeNow, lastSample, finishNow, restartNow, loadNow;

  always_comb begin
    stopReq    = (chanCode == STOP_CODE);
    busy       = (state != ST_IDLE);
    startOk    = (state == ST_IDLE) && startReq && !stopReq;
    phaseDone  = busy && tick && !stopReq && (phaseCnt == '0);
    takeNow    = phaseDone && (state == ST_CONVERT);
    lastSample = (sampleCnt == ((MAX_AVG_LOG2+1)'(1) << avgLog2) - (MAX_AVG_LOG2+1)'(1));
    finishNow  = takeNow && lastSample;
    restartNow = finishNow && contMode;
    loadNow    = startOk || restartNow;
    sampleTake = takeNow;
    divRestart = startOk;
    strobe.clear  = startOk;
    strobe.take   = takeNow;
    strobe.finish = finishNow;
    strobe.shift  = avgLog2;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phaseCnt  <= '0;
      lstCyc    <= PHASE_W'(3);
      sampleCnt <= '0;
      avgLog2   <= '0;
      divLog2   <= '0;
    end else if (loadNow) begin
      divLog2   <= divLog2Of(cfgWord);
      lstCyc    <= lstOf(cfgWord);
      avgLog2   <= avgLog2Of(avgEnable, cfgWord);
      state     <= ST_STARTUP;
      phaseCnt  <= PHASE_W'(STARTUP_CYC - 1);
      sampleCnt <= '0;
    end else if (busy && tick) begin
      if (stopReq) begin
        state <= ST_IDLE;
      end else if (phaseCnt != '0) begin
        phaseCnt <= phaseCnt - 1'b1;
      end else begin
        case (state)
          ST_STARTUP: begin
            state    <= ST_LSAMP;
            phaseCnt <= lstCyc - 1'b1;
          end
          ST_LSAMP: begin
            state    <= ST_CONVERT;
            phaseCnt <= PHASE_W'(BCT_CYC - 1);
          end
          ST_CONVERT: begin
            if (lastSample) begin
              state <= ST_IDLE;
            end else begin
              sampleCnt <= sampleCnt + 1'b1;
              state     <= ST_LSAMP;
              phaseCnt  <= lstCyc - 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R3: an accepted start makes the block busy on the next cycle
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startReq && chanCode != STOP_CODE) |=> busy);
  // R9: stop code at an ADC enable returns to idle
  p_stop_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && tick && chanCode == STOP_CODE) |=> !busy);
  // R8: without continuous mode the last sample ends the conversion
  p_finish_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTake && lastSample && !contMode) |=> !busy);
  // R4: a phase never counts beyond the longest window
  p_phase_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (phaseCnt <= PHASE_W'(BCT_CYC - 1)));
endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int ACC_W  = CODE_W + MAX_AVG_LOG2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CODE_W-1:0] sampleCode,
  output logic              resultValid,
  output logic [CODE_W-1:0] resultData
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] avgVal;

  always_comb begin
    sum    = acc + ACC_W'(sampleCode);
    avgVal = sum >> strobe.shift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc         <= '0;
      resultValid <= 1'b0;
      resultData  <= '0;
    end else begin
      resultValid <= 1'b0;
      if (strobe.clear) begin
        acc <= '0;
      end else if (strobe.take) begin
        if (strobe.finish) begin
          resultData  <= avgVal[CODE_W-1:0];
          resultValid <= 1'b1;
          acc         <= '0;
        end else begin
          acc <= sum;
        end
      end
    end
  end

  // R7: result strobe lasts one cycle
  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);
  // R6: a result always follows a sample capture
  p_valid_after_take_r6: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(strobe.take));
  // R6: accumulation never wraps for the allowed sample counts
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && !strobe.clear) |-> (sum >= acc));
endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
  import adc_seq_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [4:0]        chanCode,
  input  logic [15:0]       cfgWord,
  input  logic              avgEnable,
  input  logic              contMode,
  input  logic [CODE_W-1:0] sampleCode,
  output logic              sampleTake,
  output logic              busy,
  output logic              resultValid,
  output logic [CODE_W-1:0] resultData
);
  localparam int ACC_W = CODE_W + MAX_AVG_LOG2;

  logic       tick;
  logic       divRestart;
  logic [2:0] divLog2;
  dpStrobe_t  strobe;

  adc_seq_clkdiv #(.DIV_W(DIV_W)) uDiv (
    .clk(clk), .rstN(rstN), .run(busy), .restart(divRestart),
    .divLog2(divLog2), .tick(tick)
  );

  adc_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .chanCode(chanCode),
    .cfgWord(cfgWord), .avgEnable(avgEnable), .contMode(contMode),
    .tick(tick), .busy(busy), .sampleTake(sampleTake),
    .divRestart(divRestart), .divLog2(divLog2), .strobe(strobe)
  );

  adc_seq_datapath #(.CODE_W(CODE_W), .ACC_W(ACC_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleCode(sampleCode),
    .resultValid(resultValid), .resultData(resultData)
  );
endmodule

// File: tb/sim_adc_conv_sequencer.sv
module sim_adc_conv_sequencer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [4:0]  chanCode = 5'd0;
  logic [15:0] cfgWord = 16'd0;
  logic        avgEnable = 1'b0;
  logic        contMode = 1'b0;
  logic [11:0] sampleCode = 12'd0;
  logic        sampleTake, busy, resultValid;
  logic [11:0] resultData;

  int total = 0;
  int bad = 0;
  int tbSum = 0;
  int tbTakes = 0;
  int validCount = 0;
  bit forceMax = 1'b0;

  always #2 clk = ~clk;

  adc_conv_sequencer u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .chanCode(chanCode),
    .cfgWord(cfgWord), .avgEnable(avgEnable), .contMode(contMode),
    .sampleCode(sampleCode), .sampleTake(sampleTake), .busy(busy),
    .resultValid(resultValid), .resultData(resultData)
  );

  always @(negedge clk) begin
    if (resultValid) validCount++;
    if (sampleTake) begin
      tbSum += int'(sampleCode);
      tbTakes++;
    end else begin
      sampleCode = forceMax ? 12'hFFF : 12'($urandom);
    end
  end

  function automatic int divOf(input logic [15:0] c);
    if (c[6:5] == 2'b11 && c[1:0] == 2'b01) return 16;
    return 1 << c[6:5];
  endfunction
  function automatic int lstLen(input logic [15:0] c);
    return c[4] ? 13 + 4 * int'(c[9:8]) : 3 + 2 * int'(c[9:8]);
  endfunction
  function automatic int avgShift(input logic [15:0] c, input bit en);
    return en ? 2 + int'(c[15:14]) : 0;
  endfunction
  function automatic int expLat(input logic [15:0] c, input bit en);
    return divOf(c) * (6 + (1 << avgShift(c, en)) * (25 + lstLen(c)));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitValid(output int n);
    n = 0;
    while (!resultValid && n < 30000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic runConv(input logic [15:0] c, input bit en, input string tag);
    int n;
    @(negedge clk);
    cfgWord = c; avgEnable = en; contMode = 1'b0; chanCode = 5'd3; startReq = 1'b1;
    @(posedge clk);
    tbSum = 0; tbTakes = 0;
    @(negedge clk);
    startReq = 1'b0;
    waitValid(n);
    check(n == expLat(c, en), tag, n, expLat(c, en));
    check(tbTakes == (1 << avgShift(c, en)), "R5 take count", tbTakes, 1 << avgShift(c, en));
    check(int'(resultData) == (tbSum >> avgShift(c, en)), "R6 average", int'(resultData),
          tbSum >> avgShift(c, en));
    @(negedge clk);
    check(!resultValid, "R7 one-cycle valid", int'(resultValid), 0);
    check(!busy, "R8 idle after single", int'(busy), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int vc;
    logic [15:0] c;
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    check(!busy && !resultValid && !sampleTake, "R1 reset outputs",
          int'({busy, resultValid, sampleTake}), 0);
    rstN = 1'b1;

    runConv(16'h0000, 1'b0, "R3 latency base");
    runConv(16'h0330, 1'b0, "R4 long-sample 25 div2");
    runConv(16'h0210, 1'b0, "R4 long-sample 21");
    forceMax = 1'b1;
    runConv(16'hC240, 1'b1, "R5 32 samples div4");
    forceMax = 1'b0;
    runConv(16'h0061, 1'b0, "R2 divide by 16");
    runConv(16'h0062, 1'b0, "R2 divide by 8 other select");
    runConv(16'h4000, 1'b1, "R5 8 samples");
    for (int i = 0; i < 6; i++) begin
      c = 16'($urandom);
      c[6:5] = 2'($urandom_range(0, 2));
      runConv(c, 1'($urandom), "R6 random config");
    end

    // R8 continuous mode
    @(negedge clk);
    cfgWord = 16'h0000; avgEnable = 1'b1; contMode = 1'b1; chanCode = 5'd1; startReq = 1'b1;
    @(posedge clk);
    tbSum = 0; tbTakes = 0;
    @(negedge clk);
    startReq = 1'b0;
    waitValid(n);
    check(n == 118, "R8 first continuous", n, 118);
    check(int'(resultData) == (tbSum >> 2), "R8 first average", int'(resultData), tbSum >> 2);
    tbSum = 0; tbTakes = 0;
    @(posedge clk); @(negedge clk);
    check(busy && !resultValid, "R8 restarted", int'(busy), 1);
    waitValid(n);
    check(n + 1 == 118, "R8 second latency", n + 1, 118);
    check(int'(resultData) == (tbSum >> 2), "R8 second average", int'(resultData), tbSum >> 2);
    contMode = 1'b0;
    tbSum = 0; tbTakes = 0;
    @(posedge clk); @(negedge clk);
    waitValid(n);
    check(n + 1 == 118, "R8 final latency", n + 1, 118);
    @(negedge clk);
    check(!busy, "R8 idle after clear", int'(busy), 0);

    // R9 abort by stop code
    @(negedge clk);
    cfgWord = 16'hC371; avgEnable = 1'b1; chanCode = 5'd2; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (300) @(negedge clk);
    vc = validCount;
    chanCode = 5'h1F;
    repeat (17) @(negedge clk);
    check(!busy, "R9 abort idle", int'(busy), 0);
    repeat (600) @(negedge clk);
    check(validCount == vc, "R9 no result after abort", validCount - vc, 0);

    // R9 start with stop code ignored
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(!busy, "R9 start ignored", int'(busy), 0);
    repeat (3) @(negedge clk);
    check(!busy && validCount == vc, "R9 stays idle", int'(busy), 0);
    chanCode = 5'd0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule